// File: doc/BRIEF.md
# Calibration Pulse Period Estimator

This block sits beside a processor that sleeps most of the time and is woken by an external low-power interval timer. That timer sends one calibration pulse per wake-up. The pulse is as wide as one period of the timer's slow, imprecise time base, and it starts half a base period after the switch-enable line falls. The estimator times the high phase of that pulse against an accurate local reference clock. It then multiplies the width by the factor that belongs to the interval code the timer is strapped to. The product is the true wake-up interval, expressed in reference clock cycles.

Software, or a sequencer, arms the unit with a one-cycle strobe and supplies the 3-bit interval code. The unit synchronises the pulse, waits for a clean rising edge and counts the high cycles until the falling edge. It then scales the count and raises a one-cycle valid strobe. The width, the estimate and an overflow flag stay on the outputs until the next arm.

The controller is a six-state machine:

- IDLE holds the results.
- WAIT_LOW is entered when the unit is armed while the pulse is already high.
- WAIT_RISE waits for a synchronised rising edge.
- COUNT counts the high cycles.
- SCALE registers the product.
- DONE drives valid.

Its transitions are:

- An arm moves any state to WAIT_LOW if the synchronised pulse is high, and to WAIT_RISE otherwise.
- WAIT_LOW goes to WAIT_RISE when the pulse goes low.
- WAIT_RISE goes to COUNT on a rising edge.
- COUNT goes to SCALE on a falling edge or when the counter saturates.
- SCALE always goes to DONE.
- DONE always goes to IDLE.

Top module: `cal_period_estimator`

## Requirements
- R1: The pulse input passes through a two-flop synchroniser. The measured width equals the number of rising clock edges at which the input was sampled high, counted from the synchronised rising edge to the synchronised falling edge.
- R2: Pulses that arrive while the unit is not armed are ignored. No valid strobe appears, and the width stays where it was.
- R3: A pulse that is already high when the unit is armed is ignored. The unit waits for it to go low and then measures the next complete pulse.
- R4: The estimate equals the width times a factor chosen by code_i: 000→1024, 001→2048, 010→4096, 011→6400, 100→8192, 101→16384, 110→32768, 111→65536.
- R5: Code 011 scales by 6400, formed from a sum of three shifted copies of the width, with no multiplier.
- R6: The counter saturates at 2^CNT_W−1. A pulse longer than that ends the measurement at saturation, with overflow_o=1, width_o at that maximum and valid_o still pulsed. A pulse of exactly 2^CNT_W−1 cycles does not overflow.
- R7: valid_o is high for exactly one cycle. The width, the estimate and the overflow flag hold until the next arm, and are all 0 in the cycle after an arm.
- R8: After reset all outputs are 0 and the unit is idle, not armed.
- R9: An arm during a measurement abandons that measurement and restarts the arming sequence.
- R10: The code is captured at arm. Changes on code_i afterwards have no effect on the estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Accurate reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_pulse_i | input | 1 | Calibration pulse from the interval timer (asynchronous) |
| arm_i | input | 1 | One-cycle strobe that starts a measurement |
| code_i | input | 3 | Interval code selecting the scale factor |
| width_o | output | CNT_W | Measured pulse width in reference cycles |
| estimate_o | output | CNT_W+16 | Estimated interval in reference cycles |
| valid_o | output | 1 | One-cycle strobe when the results are ready |
| overflow_o | output | 1 | Width counter saturated before the falling edge |

## Verification
An arm can land in the same cycle as the valid strobe. In that cycle the end of one measurement meets the start of the next. The bench provokes this by raising arm_i at the very clock edge where DONE is left, right after it sees valid_o. It then requires three things: the strobe lasted one cycle, every result reads 0 on the next cycle, and a following pulse is measured and scaled correctly. A second collision is the counter saturating against the falling edge of the pulse. It is judged with pulses of exactly the maximum width and one cycle longer.

// File: rtl/cal_est_pkg.sv
package cal_est_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_LOW,
        ST_WAIT_RISE,
        ST_COUNT,
        ST_SCALE,
        ST_DONE
    } cal_state_e;

    // Scale factor per interval code, used by checkers as a reference.
    function automatic logic [16:0] interval_factor(input logic [2:0] code);
        logic [16:0] f;
        unique case (code)
            3'd0: f = 17'd1024;
            3'd1: f = 17'd2048;
            3'd2: f = 17'd4096;
            3'd3: f = 17'd6400;
            3'd4: f = 17'd8192;
            3'd5: f = 17'd16384;
            3'd6: f = 17'd32768;
            3'd7: f = 17'd65536;
            default: f = 17'd0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/cal_pulse_sync.sv
module cal_pulse_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] shreg;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[DEPTH-2:0], din_i};
        end
    end

    always_comb begin
        level_o = shreg[SYNC_STAGES-1];
        rise_o  = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
        fall_o  = ~shreg[SYNC_STAGES-1] & shreg[SYNC_STAGES];
    end

    // R1: a synchronised edge is preceded by the opposite level
    sync_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> $past(!level_o));

endmodule

// File: rtl/cal_width_counter.sv
module cal_width_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             sat_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(1);
        end else if (inc_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        count_o = cnt_q;
        sat_o   = (cnt_q == CNT_MAX);
    end

    // R1: without a clear the count never goes down
    count_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> (count_o >= $past(count_o)));

endmodule

// File: rtl/cal_interval_scaler.sv
module cal_interval_scaler #(
    parameter int CNT_W = 20
) (
    input  logic [CNT_W-1:0]    width_i,
    input  logic [2:0]          code_i,
    output logic [CNT_W+15:0]   scaled_o
);
    localparam int EST_W = CNT_W + 16;

    logic [EST_W-1:0] ext;

    always_comb begin
        ext = EST_W'(width_i);
        unique case (code_i)
            3'd0: scaled_o = ext << 10;
            3'd1: scaled_o = ext << 11;
            3'd2: scaled_o = ext << 12;
            3'd3: scaled_o = (ext << 12) + (ext << 11) + (ext << 8);
            3'd4: scaled_o = ext << 13;
            3'd5: scaled_o = ext << 14;
            3'd6: scaled_o = ext << 15;
            3'd7: scaled_o = ext << 16;
            default: scaled_o = '0;
        endcase
    end

endmodule

// File: rtl/cal_period_estimator.sv
module cal_period_estimator
    import cal_est_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cal_pulse_i,
    input  logic               arm_i,
    input  logic [2:0]         code_i,
    output logic [CNT_W-1:0]   width_o,
    output logic [CNT_W+15:0]  estimate_o,
    output logic               valid_o,
    output logic               overflow_o
);
    localparam int EST_W = CNT_W + 16;

    cal_state_e state_q, state_d;

    logic             lvl, rise, fall;
    logic [CNT_W-1:0] cnt;
    logic             sat;
    logic             cnt_load, cnt_inc;
    logic [2:0]       code_q;
    logic [EST_W-1:0] est_q, scaled;
    logic             ovf_q;

    cal_pulse_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .din_i   (cal_pulse_i),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    always_comb begin
        cnt_load = (state_q == ST_WAIT_RISE) && rise && !arm_i;
        cnt_inc  = (state_q == ST_COUNT) && lvl && !fall && !arm_i;
    end

    cal_width_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (arm_i),
        .load_i  (cnt_load),
        .inc_i   (cnt_inc),
        .count_o (cnt),
        .sat_o   (sat)
    );

    cal_interval_scaler #(.CNT_W(CNT_W)) u_scale (
        .width_i  (cnt),
        .code_i   (code_q),
        .scaled_o (scaled)
    );

    // Next-state logic; an arm overrides every state.
    always_comb begin
        state_d = state_q;
        if (arm_i) begin
            state_d = lvl ? ST_WAIT_LOW : ST_WAIT_RISE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_WAIT_LOW:  if (!lvl) state_d = ST_WAIT_RISE;
                ST_WAIT_RISE: if (rise) state_d = ST_COUNT;
                ST_COUNT:     if (!lvl || sat) state_d = ST_SCALE;
                ST_SCALE:     state_d = ST_DONE;
                ST_DONE:      state_d = ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            code_q <= '0;
            est_q  <= '0;
            ovf_q  <= 1'b0;
        end else if (arm_i) begin
            code_q <= code_i;
            est_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if ((state_q == ST_COUNT) && lvl && sat) begin
                ovf_q <= 1'b1;
            end
            if (state_q == ST_SCALE) begin
                est_q <= scaled;
            end
        end
    end

    // Outputs
    always_comb begin
        valid_o    = (state_q == ST_DONE);
        width_o    = cnt;
        estimate_o = est_q;
        overflow_o = ovf_q;
    end

    // R7
    valid_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R7
    arm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> (width_o == '0 && estimate_o == '0 && !overflow_o));

    // R6
    ovf_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overflow_o |-> (width_o == {CNT_W{1'b1}}));

    // R4
    est_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (estimate_o == EST_W'(width_o) * EST_W'(interval_factor(code_q))));

endmodule

// File: tb/tb_cal_period_estimator.sv
module tb_cal_period_estimator;
    localparam int CW = 10;
    localparam int EW = CW + 16;
    localparam int MAXW = (1 << CW) - 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          pulse = 1'b0;
    logic          arm = 1'b0;
    logic [2:0]    code = 3'd0;
    logic [CW-1:0] width;
    logic [EW-1:0] est;
    logic          valid, ovf;

    cal_period_estimator #(.CNT_W(CW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .cal_pulse_i(pulse), .arm_i(arm),
        .code_i(code), .width_o(width), .estimate_o(est),
        .valid_o(valid), .overflow_o(ovf)
    );

    int checks = 0, fails = 0, vcount = 0;
    bit busy = 0, finished = 0;

    always @(posedge clk) if (rst_n && valid) vcount++;

    function automatic longint fac(int c);
        case (c)
            0: return 1024;   1: return 2048;  2: return 4096;  3: return 6400;
            4: return 8192;   5: return 16384; 6: return 32768; default: return 65536;
        endcase
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_arm(int c);
        @(negedge clk); code = 3'(c); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic drive_pulse(int n);
        @(negedge clk); pulse = 1'b1;
        repeat (n) @(negedge clk);
        pulse = 1'b0;
        busy = 0;
    endtask

    task automatic wait_valid(output bit got);
        got = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (valid) begin got = 1; break; end
        end
    endtask

    // Measure one pulse with the current arming and check all results.
    task automatic measure(int c, int n, bit exp_ovf, string req);
        bit got;
        int exp_w = exp_ovf ? MAXW : n;
        busy = 1;
        fork drive_pulse(n); join_none
        wait_valid(got);
        chk(got, {req, " valid seen"}, got, 1);
        chk(width == CW'(exp_w), {req, " width"}, width, exp_w);
        chk(est == EW'(longint'(exp_w) * fac(c)), {req, " estimate"}, est, longint'(exp_w) * fac(c));
        chk(ovf == exp_ovf, {req, " R6 overflow flag"}, ovf, exp_ovf);
        @(negedge clk);
        chk(!valid, "R7 valid one cycle", valid, 0);
        wait (busy == 0);
        repeat (4) @(negedge clk);
        chk(width == CW'(exp_w), "R7 width held", width, exp_w);
    endtask

    task automatic t_reset();
        chk(width == 0 && est == 0 && !valid && !ovf, "R8 reset outputs", {width, est}, 0);
    endtask

    task automatic t_unarmed();
        int v0 = vcount;
        busy = 1;
        drive_pulse(20);
        repeat (10) @(negedge clk);
        chk(vcount == v0, "R2 no valid when unarmed", vcount, v0);
        chk(width == 0, "R2 width untouched", width, 0);
    endtask

    task automatic t_codes();
        for (int c = 0; c < 8; c++) begin
            do_arm(c);
            repeat (3) @(negedge clk);
            measure(c, 20 + 7 * c, 0, (c == 3) ? "R5" : "R4 R1");
        end
    endtask

    task automatic t_code_capture();
        do_arm(2);
        code = 3'd7;
        repeat (2) @(negedge clk);
        measure(2, 40, 0, "R10");
    endtask

    task automatic t_high_at_arm();
        int v0;
        @(negedge clk); pulse = 1'b1;
        repeat (5) @(negedge clk);
        v0 = vcount;
        do_arm(1);
        repeat (30) @(negedge clk);
        pulse = 1'b0;
        repeat (6) @(negedge clk);
        chk(vcount == v0, "R3 stale pulse ignored", vcount, v0);
        chk(width == 0, "R3 width zero", width, 0);
        measure(1, 25, 0, "R3");
    endtask

    task automatic t_rearm();
        int v0 = vcount;
        do_arm(5);
        busy = 1;
        fork drive_pulse(50); join_none
        repeat (20) @(negedge clk);
        do_arm(6);
        wait (busy == 0);
        repeat (6) @(negedge clk);
        chk(vcount == v0, "R9 abandoned measurement silent", vcount, v0);
        measure(6, 33, 0, "R9");
    endtask

    task automatic t_overflow();
        do_arm(0);
        measure(0, MAXW, 0, "R6 exact max");
        do_arm(4);
        measure(4, MAXW + 1, 1, "R6 overflow");
        do_arm(4);
        chk(!ovf && width == 0 && est == 0, "R7 arm clears overflow", ovf, 0);
    endtask

    task automatic t_arm_on_valid();
        bit got;
        do_arm(3);
        busy = 1;
        fork drive_pulse(12); join_none
        wait_valid(got);
        chk(got, "R7 valid before collision", got, 1);
        code = 3'd4; arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        chk(!valid, "R7 valid one cycle under arm", valid, 0);
        chk(width == 0 && est == 0, "R7 cleared by arm", width, 0);
        wait (busy == 0);
        measure(4, 15, 0, "R7 R4 after collision");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_unarmed();
        t_codes();
        t_code_capture();
        t_high_at_arm();
        t_rearm();
        t_overflow();
        t_arm_on_valid();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule